// File: doc/BRIEF.md
# Context-Swapped Multichannel DMA Engine

This block serves several logical DMA channels with one transfer engine. No channel has its own address or count registers. Each channel's working record is held in a small single-port state RAM. The record has four words: source address, destination address, remaining byte count and a descriptor pointer. When the engine is idle, a round-robin arbiter picks one pending channel. A channel is pending when its request line is high and its enable bit is set. The engine then copies that channel's record into its working registers and moves the data one 32-bit word at a time, as a read beat followed by a write beat on a simple master port. When the count is used up, it writes the updated record back to the state RAM.

Software programs records through a host port that shares the state RAM with the engine. Writing a nonzero count arms the channel's enable bit. When a run ends, the bit is cleared and the channel's done flag pulses for one cycle. While a channel is being serviced, host accesses to its record are held off. This keeps the host from racing the record held in the engine.

Top module: `dmacx_top`

## Requirements
- R1: At most one channel is in service at a time. While `busy` stays high, `act_ch` does not change.
- R2: A record is addressed by channel and field index. Field 0 is the source address, 1 the destination address, 2 the byte count and 3 the descriptor pointer. The host port reads and writes these fields.
- R3: A run starts with a load of the four record fields, one state-RAM cycle each. The first bus request comes exactly 4 cycles after `busy` rises. `m_req` is never high while the engine is idle.
- R4: After the final write beat is acknowledged, the engine writes all four fields back in four cycles, and `done` is seen 5 cycles after that acknowledge. A later host read of the record shows both addresses advanced by 4 per beat, a count of 0 and the pointer unchanged.
- R5: A channel is eligible when its `ch_req` bit is high and its enable bit is set. The grant goes to the first eligible channel after the last one granted, in ascending index order with wrap-around. After reset, channel 0 has top priority. Arbitration takes place only while the engine is idle.
- R6: Each beat reads one word at the current source address (`m_we`=0) and then writes that same word to the current destination address (`m_we`=1). Each phase ends on `m_ack`. After a beat, both addresses grow by 4 and the count drops by 4, saturating at 0. A trailing partial word still moves one whole word.
- R7: At the end of a run the channel's enable bit clears and its bit in `done` is high for exactly one cycle. Only one `done` bit is ever high. A request from a channel whose enable bit is clear starts no run.
- R8: A host write of a nonzero value to field 2 sets the channel's enable bit. A write of zero clears it.
- R9: A host access to the record of the channel in service is held off (`host_gnt` low) until the run ends. Once granted, a write takes effect after the run's write-back.
- R10: During and right after reset, `busy`, `m_req` and `done` are low and every enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ch_req | input | NCH | Per-channel transfer request |
| host_req | input | 1 | Host record access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ch | input | $clog2(NCH) | Channel whose record is accessed |
| host_fld | input | 2 | Field index (0 src, 1 dst, 2 count, 3 pointer) |
| host_wdata | input | 32 | Host write data |
| host_gnt | output | 1 | Access performed this cycle |
| host_rdata | output | 32 | Field read data, valid with host_gnt |
| m_req | output | 1 | Bus beat request |
| m_we | output | 1 | 1 = write phase, 0 = read phase |
| m_addr | output | 32 | Bus byte address |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with m_ack |
| m_ack | input | 1 | Phase completion |
| busy | output | 1 | Engine loading, transferring or writing back |
| act_ch | output | $clog2(NCH) | Channel in service |
| done | output | NCH | One-cycle completion pulse per channel |

## Verification
A directed single-channel run with a three-word count checks beat addresses and data, the load and write-back timing, and the saved record. Raising all four requests at once after a known last grant separates true round-robin order from fixed priority. Holding a request high after its run, and arming with a zero count, show whether completion and a zero count really disarm a channel. A host write aimed at the channel in service tells real back-pressure apart from a write that corrupts the active record. Random batches of channels with random counts and slow memory acknowledges then mix arbitration, runs of different lengths and bus stalls.

// File: rtl/dmacx_pkg.sv
package dmacx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RD,
    ST_WR,
    ST_WB
  } eng_state_t;

  // record field indices inside a channel's block of the state RAM
  localparam logic [1:0] FLD_SRC = 2'd0;
  localparam logic [1:0] FLD_DST = 2'd1;
  localparam logic [1:0] FLD_CNT = 2'd2;
  localparam logic [1:0] FLD_PTR = 2'd3;

  localparam logic [31:0] WORD_BYTES = 32'd4;

  function automatic logic [31:0] step_addr(input logic [31:0] a);
    return a + WORD_BYTES;
  endfunction

  // saturating count decrement: a partial last word still counts as a beat
  function automatic logic [31:0] step_cnt(input logic [31:0] c);
    return (c > WORD_BYTES) ? (c - WORD_BYTES) : 32'd0;
  endfunction

endpackage

// File: rtl/dmacx_ctx_ram.sv
module dmacx_ctx_ram #(
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/dmacx_rr_arb.sv
module dmacx_rr_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  input  logic           take,
  output logic           any,
  output logic [CHW-1:0] pick
);

  logic [CHW-1:0] last_q;

  always_comb begin
    int idx;
    any  = 1'b0;
    pick = last_q;
    for (int k = 1; k <= NCH; k++) begin
      idx = (int'(last_q) + k) % NCH;
      if (!any && elig[idx]) begin
        any  = 1'b1;
        pick = CHW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= CHW'(NCH - 1);
    else if (take) last_q <= pick;
  end

endmodule

// File: rtl/dmacx_engine.sv
module dmacx_engine
  import dmacx_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  input  logic [31:0]    ram_rdata,
  output logic           ram_use,
  output logic           ram_we,
  output logic [1:0]     ram_fld,
  output logic [31:0]    ram_wdata,
  output logic           m_req,
  output logic           m_we,
  output logic [31:0]    m_addr,
  output logic [31:0]    m_wdata,
  input  logic [31:0]    m_rdata,
  input  logic           m_ack,
  output logic           busy,
  output logic [CHW-1:0] act_ch,
  output logic           ev_finish
);

  eng_state_t     st;
  logic [1:0]     fld;
  logic [CHW-1:0] r_ch;
  logic [31:0]    r_src, r_dst, r_cnt, r_ptr, r_hold;
  logic [31:0]    cnt_next;
  logic           ev_beat_done;

  assign cnt_next     = step_cnt(r_cnt);
  assign ev_beat_done = (st == ST_WR) && m_ack;
  assign ev_finish    = (st == ST_WB) && (fld == FLD_PTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fld    <= '0;
      r_ch   <= '0;
      r_src  <= '0;
      r_dst  <= '0;
      r_cnt  <= '0;
      r_ptr  <= '0;
      r_hold <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          r_ch <= start_ch;
          fld  <= '0;
          st   <= ST_LOAD;
        end
        ST_LOAD: begin
          case (fld)
            FLD_SRC: r_src <= ram_rdata;
            FLD_DST: r_dst <= ram_rdata;
            FLD_CNT: r_cnt <= ram_rdata;
            default: r_ptr <= ram_rdata;
          endcase
          fld <= fld + 2'd1;
          if (fld == FLD_PTR) st <= (r_cnt == 32'd0) ? ST_WB : ST_RD;
        end
        ST_RD: if (m_ack) begin
          r_hold <= m_rdata;
          st     <= ST_WR;
        end
        ST_WR: if (m_ack) begin
          r_src <= step_addr(r_src);
          r_dst <= step_addr(r_dst);
          r_cnt <= cnt_next;
          st    <= (cnt_next == 32'd0) ? ST_WB : ST_RD;
        end
        ST_WB: begin
          fld <= fld + 2'd1;
          if (fld == FLD_PTR) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (fld)
      FLD_SRC: ram_wdata = r_src;
      FLD_DST: ram_wdata = r_dst;
      FLD_CNT: ram_wdata = r_cnt;
      default: ram_wdata = r_ptr;
    endcase
  end

  assign ram_use = (st == ST_LOAD) || (st == ST_WB);
  assign ram_we  = (st == ST_WB);
  assign ram_fld = fld;
  assign m_req   = (st == ST_RD) || (st == ST_WR);
  assign m_we    = (st == ST_WR);
  assign m_addr  = (st == ST_WR) ? r_dst : r_src;
  assign m_wdata = r_hold;
  assign busy    = (st != ST_IDLE);
  assign act_ch  = r_ch;

  // R1: the channel in service never changes in the middle of a run
  p_no_switch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(r_ch));

  // R3: bus traffic for a run only begins right after the record load
  p_load_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> $past(st) == ST_LOAD);

  // R4: a run always ends by writing back its last record field
  p_run_ends_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(st) == ST_WB && $past(fld) == FLD_PTR));

  // R6: each completed beat advances both addresses by one word
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat_done |=> (r_src == $past(r_src) + 32'd4 && r_dst == $past(r_dst) + 32'd4));

endmodule

// File: rtl/dmacx_top.sv
module dmacx_top
  import dmacx_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH),
  localparam int RAW = CHW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_req,
  input  logic           host_req,
  input  logic           host_wr,
  input  logic [CHW-1:0] host_ch,
  input  logic [1:0]     host_fld,
  input  logic [31:0]    host_wdata,
  output logic           host_gnt,
  output logic [31:0]    host_rdata,
  output logic           m_req,
  output logic           m_we,
  output logic [31:0]    m_addr,
  output logic [31:0]    m_wdata,
  input  logic [31:0]    m_rdata,
  input  logic           m_ack,
  output logic           busy,
  output logic [CHW-1:0] act_ch,
  output logic [NCH-1:0] done
);

  logic [NCH-1:0] en_q, done_q, elig;
  logic           arb_any, start;
  logic [CHW-1:0] arb_pick, eng_ch;
  logic           eng_busy, eng_ram_use, eng_ram_we, ev_finish;
  logic [1:0]     eng_fld;
  logic [31:0]    eng_ram_wdata, ram_rdata, ram_wdata;
  logic [RAW-1:0] ram_addr;
  logic           ram_we, host_gnt_w, host_arm;

  assign elig  = ch_req & en_q;
  assign start = arb_any && !eng_busy;

  dmacx_rr_arb #(.NCH(NCH)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .elig (elig),
    .take (start),
    .any  (arb_any),
    .pick (arb_pick)
  );

  dmacx_engine #(.NCH(NCH)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_ch (arb_pick),
    .ram_rdata(ram_rdata),
    .ram_use  (eng_ram_use),
    .ram_we   (eng_ram_we),
    .ram_fld  (eng_fld),
    .ram_wdata(eng_ram_wdata),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .m_rdata  (m_rdata),
    .m_ack    (m_ack),
    .busy     (eng_busy),
    .act_ch   (eng_ch),
    .ev_finish(ev_finish)
  );

  // host gets the single RAM port when the engine is off it and the
  // target record is not the one in service
  assign host_gnt_w = host_req && !eng_ram_use && !(eng_busy && host_ch == eng_ch);
  assign host_arm   = host_gnt_w && host_wr && (host_fld == FLD_CNT);

  always_comb begin
    if (eng_ram_use) begin
      ram_addr  = {eng_ch, eng_fld};
      ram_we    = eng_ram_we;
      ram_wdata = eng_ram_wdata;
    end else begin
      ram_addr  = {host_ch, host_fld};
      ram_we    = host_gnt_w && host_wr;
      ram_wdata = host_wdata;
    end
  end

  dmacx_ctx_ram #(.AW(RAW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      done_q <= '0;
    end else begin
      if (host_arm)  en_q[host_ch] <= (host_wdata != 32'd0);
      if (ev_finish) en_q[eng_ch]  <= 1'b0;
      done_q <= ev_finish ? (NCH'(1) << eng_ch) : '0;
    end
  end

  assign host_gnt   = host_gnt_w;
  assign host_rdata = ram_rdata;
  assign busy       = eng_busy;
  assign act_ch     = eng_ch;
  assign done       = done_q;

  // R7: completion pulses never overlap
  p_done_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_q));

  // R7: a completed channel is disarmed when its pulse is seen
  p_done_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_q) |-> ((done_q & en_q) == '0));

  // R5: a run only starts if some channel was eligible when idle
  p_start_needs_elig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(elig) != '0);

  // R10: nothing is armed coming out of reset
  p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> en_q == '0);

endmodule

// File: tb/dmacx_top_test.sv
module dmacx_top_test;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [NCH-1:0] ch_req = '0;
  logic           host_req = 1'b0, host_wr = 1'b0;
  logic [CHW-1:0] host_ch = '0;
  logic [1:0]     host_fld = '0;
  logic [31:0]    host_wdata = '0;
  logic           host_gnt;
  logic [31:0]    host_rdata;
  logic           m_req, m_we;
  logic [31:0]    m_addr, m_wdata;
  logic [31:0]    m_rdata = '0;
  logic           m_ack = 1'b0;
  logic           busy;
  logic [CHW-1:0] act_ch;
  logic [NCH-1:0] done;

  dmacx_top #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req),
    .host_req(host_req), .host_wr(host_wr), .host_ch(host_ch), .host_fld(host_fld),
    .host_wdata(host_wdata), .host_gnt(host_gnt), .host_rdata(host_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack), .busy(busy), .act_ch(act_ch), .done(done)
  );

  int errs = 0, checks = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic int rr_next(input int last, input logic [NCH-1:0] m);
    for (int k = 1; k <= NCH; k++) begin
      int i;
      i = (last + k) % NCH;
      if (m[i]) return i;
    end
    return -1;
  endfunction

  logic [31:0]    exp_src [NCH], exp_dst [NCH], src0 [NCH], dst0 [NCH], ptr0 [NCH];
  int             beats_exp [NCH], beats_seen [NCH];
  logic [NCH-1:0] armed = '0;
  int             last_g = NCH - 1;
  int             busy_rise_cyc = 0, last_wr_cyc = 0, wait_n = 0;
  bit             prev_busy = 0, prev_mreq = 0;
  logic [CHW-1:0] prev_act = '0;
  logic [NCH-1:0] prev_done = '0;
  int             glog [256];
  int             glog_n = 0;

  // bus model and monitors, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      if (m_ack) m_ack = 1'b0;
      else if (m_req) begin
        if (wait_n > 0) wait_n--;
        else begin
          int c;
          c = int'(act_ch);
          if (m_we) begin
            chk(m_addr == exp_dst[c], "R6 write address", m_addr, exp_dst[c]);
            chk(m_wdata == pat(exp_src[c]), "R6 write data", m_wdata, pat(exp_src[c]));
            exp_src[c] = exp_src[c] + 32'd4;
            exp_dst[c] = exp_dst[c] + 32'd4;
            beats_seen[c]++;
            last_wr_cyc = cyc;
          end else begin
            chk(m_addr == exp_src[c], "R6 read address", m_addr, exp_src[c]);
            m_rdata = pat(m_addr);
          end
          m_ack  = 1'b1;
          wait_n = int'($urandom_range(2, 0));
        end
      end
      if (busy && !prev_busy) begin
        int e;
        e = rr_next(last_g, armed & ch_req);
        chk(int'(act_ch) == e, "R5 grant order", 32'(act_ch), 32'(e));
        last_g = int'(act_ch);
        busy_rise_cyc = cyc;
        if (glog_n < 256) begin glog[glog_n] = int'(act_ch); glog_n++; end
      end
      if (busy && prev_busy)
        chk(act_ch == prev_act, "R1 channel steady during run", 32'(act_ch), 32'(prev_act));
      if (m_req && !prev_mreq)
        chk(cyc - busy_rise_cyc == 4, "R3 load cycles before first beat",
            32'(cyc - busy_rise_cyc), 32'd4);
      if (!busy && !prev_busy) chk(!m_req, "R3 no bus request while idle", 32'(m_req), 32'd0);
      if (prev_done != '0)
        chk((done & prev_done) == '0, "R7 done lasts one cycle", 32'(done), 32'd0);
      if (done != '0) begin
        chk($onehot(done), "R7 single done bit", 32'(done), 32'd1);
        for (int ch = 0; ch < NCH; ch++) if (done[ch]) begin
          chk(beats_seen[ch] == beats_exp[ch], "R7 beats before done",
              32'(beats_seen[ch]), 32'(beats_exp[ch]));
          chk(cyc - last_wr_cyc == 5, "R4 write-back length",
              32'(cyc - last_wr_cyc), 32'd5);
          armed[ch] = 1'b0;
        end
      end
      prev_busy = busy;
      prev_mreq = m_req;
      prev_act  = act_ch;
      prev_done = done;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic host_acc(input int ch, input int f, input bit wr, input logic [31:0] wd,
                          output logic [31:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_ch = CHW'(ch); host_fld = 2'(f); host_wdata = wd;
    #2;
    while (!host_gnt) begin @(negedge clk); #2; end
    rd = host_rdata;
    if (wr && f == 2) armed[ch] = (wd != 32'd0);
    @(posedge clk); #1;
    host_req = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] n, input logic [31:0] p);
    logic [31:0] dummy;
    host_acc(ch, 0, 1'b1, s, dummy);
    host_acc(ch, 1, 1'b1, d, dummy);
    host_acc(ch, 3, 1'b1, p, dummy);
    host_acc(ch, 2, 1'b1, n, dummy);
    src0[ch] = s; dst0[ch] = d; ptr0[ch] = p;
    exp_src[ch] = s; exp_dst[ch] = d;
    beats_exp[ch] = int'((n + 32'd3) / 32'd4);
    beats_seen[ch] = 0;
  endtask

  // R2/R4: saved record after a run
  task automatic chk_rec(input int ch);
    logic [31:0] v, adv;
    adv = 32'(beats_exp[ch] * 4);
    host_acc(ch, 0, 1'b0, '0, v); chk(v == src0[ch] + adv, "R4 saved source", v, src0[ch] + adv);
    host_acc(ch, 1, 1'b0, '0, v); chk(v == dst0[ch] + adv, "R4 saved destination", v, dst0[ch] + adv);
    host_acc(ch, 2, 1'b0, '0, v); chk(v == 32'd0, "R4 saved count", v, 32'd0);
    host_acc(ch, 3, 1'b0, '0, v); chk(v == ptr0[ch], "R2 saved pointer", v, ptr0[ch]);
  endtask

  task automatic wait_quiet();
    @(negedge clk); #3;
    while (busy || m_req || (armed & ch_req) != '0) begin @(negedge clk); #3; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int seen, blocked;
    bit bad;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) begin
      exp_src[i] = '0; exp_dst[i] = '0; src0[i] = '0; dst0[i] = '0; ptr0[i] = '0;
      beats_exp[i] = 0; beats_seen[i] = 0;
    end

    // R10 reset state
    repeat (3) @(negedge clk);
    #2;
    chk(!busy, "R10 busy in reset", 32'(busy), 32'd0);
    chk(!m_req, "R10 m_req in reset", 32'(m_req), 32'd0);
    chk(done == '0, "R10 done in reset", 32'(done), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(!busy && done == '0, "R10 idle after reset", 32'(busy), 32'd0);

    // directed single run, three words (R2 R4 R6)
    prog(2, 32'h0000_1000, 32'h0000_2000, 32'd12, 32'hCAFE_0002);
    @(negedge clk); ch_req = 4'b0100;
    wait_quiet();
    chk(beats_seen[2] == 3, "R6 three beats", 32'(beats_seen[2]), 32'd3);
    chk_rec(2);

    // R7: request held after completion starts nothing
    seen = 0;
    repeat (30) begin @(negedge clk); #2; if (busy || m_req) seen++; end
    chk(seen == 0, "R7 disarmed request ignored", 32'(seen), 32'd0);
    @(negedge clk); ch_req = '0;

    // R8: a zero count does not arm
    prog(3, 32'h0000_5000, 32'h0000_6000, 32'd0, 32'h0);
    @(negedge clk); ch_req = 4'b1000;
    seen = 0;
    repeat (30) begin @(negedge clk); #2; if (busy) seen++; end
    chk(seen == 0, "R8 zero count leaves channel disarmed", 32'(seen), 32'd0);
    @(negedge clk); ch_req = '0;

    // R5: all four at once after last grant 2 -> 3,0,1,2
    for (int ch = 0; ch < NCH; ch++)
      prog(ch, 32'h0001_0000 + 32'(ch) * 32'h100, 32'h0002_0000 + 32'(ch) * 32'h100,
           32'd4, 32'h7700 + 32'(ch));
    glog_n = 0;
    @(negedge clk); ch_req = 4'b1111;
    wait_quiet();
    chk(glog_n == 4, "R5 four grants", 32'(glog_n), 32'd4);
    chk(glog[0] == 3 && glog[1] == 0 && glog[2] == 1 && glog[3] == 2, "R5 rotation order",
        32'(glog[0] * 4096 + glog[1] * 256 + glog[2] * 16 + glog[3]), 32'h3012);
    for (int ch = 0; ch < NCH; ch++) chk_rec(ch);
    @(negedge clk); ch_req = '0;

    // R9: host write to the channel in service is held off
    prog(1, 32'h0003_0000, 32'h0004_0000, 32'd40, 32'hBEEF_0001);
    @(negedge clk); ch_req = 4'b0010;
    @(negedge clk); #2;
    while (!(busy && act_ch == 2'd1)) begin @(negedge clk); #2; end
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_ch = 2'd1; host_fld = 2'd0; host_wdata = 32'hABCD_0000;
    blocked = 0; bad = 0;
    #2;
    while (!host_gnt) begin blocked++; @(negedge clk); #2; end
    if (busy && act_ch == 2'd1) bad = 1;
    @(posedge clk); #1; host_req = 1'b0;
    chk(!bad, "R9 no grant to active record", 32'(bad), 32'd0);
    chk(blocked > 0, "R9 access was held off", 32'(blocked), 32'd1);
    wait_quiet();
    host_acc(1, 0, 1'b0, '0, v);
    chk(v == 32'hABCD_0000, "R9 held write lands after write-back", v, 32'hABCD_0000);
    host_acc(1, 1, 1'b0, '0, v);
    chk(v == 32'h0004_0028, "R4 destination after ten beats", v, 32'h0004_0028);
    @(negedge clk); ch_req = '0;

    // random batches
    for (int r = 0; r < 25; r++) begin
      logic [NCH-1:0] mask;
      mask = NCH'($urandom_range(15, 1));
      for (int ch = 0; ch < NCH; ch++) if (mask[ch])
        prog(ch, 32'h0010_0000 * 32'(ch + 1) + {$urandom_range(4095, 0), 2'b00},
             32'h0800_0000 + 32'h0010_0000 * 32'(ch) + {$urandom_range(4095, 0), 2'b00},
             32'(4 * $urandom_range(8, 1)), $urandom());
      @(negedge clk); ch_req = mask;
      wait_quiet();
      for (int ch = 0; ch < NCH; ch++) if (mask[ch]) chk_rec(ch);
      @(negedge clk); ch_req = '0;
    end

    summary();
    $finish;
  end

endmodule